// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block puts a 256-byte configuration register file behind two byte-wide I/O addresses on a simple strobe bus. A write to the index address (0x3F0) chooses which configuration byte is current. A write to the data address (0x3F1) updates that byte, and a read of the data address returns it. A read of the index address returns the current index.

Each index has its own write policy. Most of the low range and a few scattered high entries are read-only. Two entries are pinned: they accept exactly one byte value and drop every other value. All other high entries accept any byte. A data write that the policy drops leaves storage untouched and raises a one-cycle reject pulse on the next cycle, so the filtering can be observed from outside.

Top module: `legacy_cfg_port`

## Requirements
- R1: A write strobe with address 0x3F0 loads the 8-bit write data into the index register at the next clock edge.
- R2: The index register changes only on a write to 0x3F0. Data reads and data writes at 0x3F1 never advance it.
- R3: A data write (write strobe, address 0x3F1) at an open index stores the byte at that index. The open indexes are 0xE0–0xE6, 0xE9–0xF6, 0xF8 and 0xFC.
- R4: A data write at a locked index changes nothing. The locked indexes are 0xFD–0xFF, 0xF9–0xFB, 0xF7 and 0x00–0xDF.
- R5: At index 0xE7 a data write is stored only when the byte is 0xFE. Any other byte is dropped and the entry keeps its value.
- R6: At index 0xE8 a data write is stored only when the byte is 0xBE. Any other byte is dropped and the entry keeps its value.
- R7: Writes to any address other than 0x3F0 or 0x3F1 change neither the index nor any stored byte.
- R8: While the read strobe is high, rd_data shows the index for address 0x3F0, shows the byte at the current index for 0x3F1, and is 0x00 for any other address. rd_data is 0x00 while no read is in progress. rd_data is combinational from the current state.
- R9: A synchronous active-low reset clears the index and every stored byte to 0x00, except entry 0xE7, which resets to 0xFE, and entry 0xE8, which resets to 0xBE.
- R10: wr_reject is high for exactly the one cycle after a data write that R4, R5 or R6 drops. It is low after every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid in the same cycle as bus_rd |
| wr_reject | output | 1 | Pulse one cycle after a dropped data write |

## Verification
The bench aims at the edges of every protected range: 0xDF against 0xE0, 0xF6 through 0xF9, 0xFB/0xFC and 0xFD/0xFF. An off-by-one range check would store a byte at a locked index, or drop one at an open index. It tries the pinned entries with the other entry's accepted value and with their own. A design that swapped or loosened the pinned values would overwrite them, and a design that dropped the byte without flagging it would leave wr_reject low. It also reads the index back after data accesses and writes to a neighbouring address, which catches auto-increment and loose address decode. A reset with dirty storage, followed by a sweep of all 256 indexes, checks the non-zero reset values and each entry's policy.

// File: rtl/legacy_cfg_pkg.sv
package legacy_cfg_pkg;

    localparam int IDX_W    = 8;
    localparam int NUM_REGS = 1 << IDX_W;

    typedef enum logic [1:0] {
        ACC_OPEN   = 2'd0,
        ACC_LOCKED = 2'd1,
        ACC_PINNED = 2'd2
    } access_e;

    // Write policy per index
    function automatic access_e classify(input logic [IDX_W-1:0] idx);
        access_e acc;
        if (idx < 8'hE0) begin
            acc = ACC_LOCKED;
        end else if (idx == 8'hE7 || idx == 8'hE8) begin
            acc = ACC_PINNED;
        end else if (idx == 8'hF7 || (idx >= 8'hF9 && idx <= 8'hFB) || idx >= 8'hFD) begin
            acc = ACC_LOCKED;
        end else begin
            acc = ACC_OPEN;
        end
        return acc;
    endfunction

    // The only value a pinned entry accepts, which is also its reset value
    function automatic logic [7:0] pinned_value(input logic [IDX_W-1:0] idx);
        logic [7:0] v;
        case (idx)
            8'hE7:   v = 8'hFE;
            8'hE8:   v = 8'hBE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/legacy_cfg_decode.sv
module legacy_cfg_decode #(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h03F0,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h03F1
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              idx_wr,
    output logic              dat_wr,
    output logic              idx_rd,
    output logic              dat_rd
);
    logic hit_idx;
    logic hit_dat;

    always_comb begin
        hit_idx = (bus_addr == INDEX_ADDR);
        hit_dat = (bus_addr == DATA_ADDR);
        idx_wr  = bus_wr && hit_idx;
        dat_wr  = bus_wr && hit_dat;
        idx_rd  = bus_rd && hit_idx;
        dat_rd  = bus_rd && hit_dat;
    end
endmodule

// File: rtl/legacy_cfg_filter.sv
module legacy_cfg_filter
    import legacy_cfg_pkg::*;
(
    input  logic             dat_wr,
    input  logic [IDX_W-1:0] index,
    input  logic [7:0]       wdata,
    output logic             commit,
    output logic             reject
);
    access_e acc;
    logic    allow;

    always_comb begin
        acc = classify(index);
        unique case (acc)
            ACC_OPEN:   allow = 1'b1;
            ACC_PINNED: allow = (wdata == pinned_value(index));
            default:    allow = 1'b0;
        endcase
        commit = dat_wr && allow;
        reject = dat_wr && !allow;
    end
endmodule

// File: rtl/legacy_cfg_store.sv
module legacy_cfg_store
    import legacy_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem_d [NUM_REGS];
    logic [7:0] mem_q [NUM_REGS];
    logic [7:0] rst_val [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_rst
        assign rst_val[g] = pinned_value(IDX_W'(g));
    end

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            mem_q[i] <= rst_n ? mem_d[i] : rst_val[i];
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/legacy_cfg_port.sv
module legacy_cfg_port
    import legacy_cfg_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] INDEX_ADDR = 16'h03F0,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'h03F1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        rd_data,
    output logic              wr_reject
);
    typedef struct packed {
        logic [IDX_W-1:0] index;
        logic             reject;
    } port_state_t;

    port_state_t st_d;
    port_state_t st_q;

    logic       idx_wr;
    logic       dat_wr;
    logic       idx_rd;
    logic       dat_rd;
    logic       commit;
    logic       reject;
    logic [7:0] sel_byte;
    logic [IDX_W-1:0] index_q;

    legacy_cfg_decode #(
        .ADDR_W    (ADDR_W),
        .INDEX_ADDR(INDEX_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) decode_i (
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .bus_addr(bus_addr),
        .idx_wr  (idx_wr),
        .dat_wr  (dat_wr),
        .idx_rd  (idx_rd),
        .dat_rd  (dat_rd)
    );

    legacy_cfg_filter filter_i (
        .dat_wr(dat_wr),
        .index (st_q.index),
        .wdata (bus_wdata),
        .commit(commit),
        .reject(reject)
    );

    legacy_cfg_store store_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (commit),
        .waddr(st_q.index),
        .wdata(bus_wdata),
        .raddr(st_q.index),
        .rdata(sel_byte)
    );

    always_comb begin
        st_d        = st_q;
        st_d.reject = reject;
        if (idx_wr) begin
            st_d.index = bus_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (idx_rd) begin
            rd_data = st_q.index;
        end else if (dat_rd) begin
            rd_data = sel_byte;
        end
    end

    assign index_q   = st_q.index;
    assign wr_reject = st_q.reject;
endmodule

// File: rtl/legacy_cfg_port_chk.sv
module legacy_cfg_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        wr_reject,
    input logic [7:0]  index_q,
    input logic [7:0]  sel_byte
);
    logic iw;
    logic dw;
    logic lk;
    assign iw = bus_wr && (bus_addr == 16'h03F0);
    assign dw = bus_wr && (bus_addr == 16'h03F1);
    assign lk = (index_q <= 8'hDF) || (index_q == 8'hF7) ||
                (index_q >= 8'hF9 && index_q <= 8'hFB) || (index_q >= 8'hFD);

    // R1
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iw |=> index_q == $past(bus_wdata));

    // R2
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iw |=> $stable(index_q));

    // R4
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dw && lk) |=> wr_reject && $stable(sel_byte));

    // R5
    pin_e7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dw && index_q == 8'hE7 && bus_wdata != 8'hFE) |=> wr_reject && sel_byte == 8'hFE);

    // R6
    pin_e8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dw && index_q == 8'hE8 && bus_wdata != 8'hBE) |=> wr_reject && sel_byte == 8'hBE);

    // R3
    open_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dw && !lk && index_q != 8'hE7 && index_q != 8'hE8) |=> !wr_reject && sel_byte == $past(bus_wdata));

    // R10
    reject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dw |=> !wr_reject);
endmodule

bind legacy_cfg_port legacy_cfg_port_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .wr_reject(wr_reject),
    .index_q  (index_q),
    .sel_byte (sel_byte)
);

// File: tb/legacy_cfg_port_tb_top.sv
module legacy_cfg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_data;
    logic        wr_reject;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    legacy_cfg_port dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .rd_data  (rd_data),
        .wr_reject(wr_reject)
    );

    // vector: {op(4) 1=read 0=write, addr(16), wdata(8), expected(8), req(8)}
    // for writes, expected is the wr_reject value one cycle later
    localparam int NV = 42;
    localparam logic [43:0] VEC [NV] = '{
        44'h1_03F0_00_00_09, // R9 index after reset
        44'h0_03F0_E0_00_01, // R1
        44'h0_03F1_5A_00_03, // R3 open 0xE0
        44'h1_03F1_00_5A_03,
        44'h1_03F0_00_E0_02, // R2 no auto-increment
        44'h0_03F0_DF_00_01,
        44'h0_03F1_11_01_04, // R4 edge 0xDF
        44'h1_03F1_00_00_04,
        44'h0_03F0_E7_00_01,
        44'h1_03F1_00_FE_09, // R9 pinned reset value
        44'h0_03F1_12_01_05, // R5 wrong value
        44'h1_03F1_00_FE_05,
        44'h0_03F1_BE_01_05, // R5 the other entry's value
        44'h0_03F1_FE_00_05, // R5 correct value
        44'h1_03F1_00_FE_05,
        44'h0_03F0_E8_00_01,
        44'h1_03F1_00_BE_09,
        44'h0_03F1_FE_01_06, // R6
        44'h1_03F1_00_BE_06,
        44'h0_03F1_BE_00_06,
        44'h0_03F0_F7_00_01,
        44'h0_03F1_44_01_04, // R4 0xF7
        44'h1_03F1_00_00_04,
        44'h0_03F0_F8_00_01,
        44'h0_03F1_44_00_03, // R3 0xF8
        44'h1_03F1_00_44_03,
        44'h0_03F0_FB_00_01,
        44'h0_03F1_77_01_04, // R4 0xFB
        44'h0_03F0_FC_00_01,
        44'h0_03F1_C3_00_03, // R3 0xFC
        44'h1_03F1_00_C3_03,
        44'h0_03F0_FF_00_01,
        44'h0_03F1_77_01_04, // R4 0xFF
        44'h1_03F1_00_00_04,
        44'h0_03F0_F6_00_01,
        44'h0_03F1_66_00_03, // R3 0xF6
        44'h0_03F2_99_00_07, // R7 neighbour address
        44'h0_03E0_F6_00_07, // R7
        44'h1_03F0_00_F6_07,
        44'h1_03F1_00_66_07,
        44'h1_03F2_00_00_08, // R8 other address reads zero
        44'h1_03F0_00_F6_08  // R8
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input int req, input logic exp_rej, input bit chk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (chk) check(req, {7'd0, wr_reject}, {7'd0, exp_rej}, "wr_reject");
    endtask

    task automatic do_read(input logic [15:0] a, input int req, input logic [7:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        check(req, rd_data, exp, "rd_data");
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic int tb_kind(input int i); // 0 open, 1 locked, 2 pinned
        if (i == 'hE7 || i == 'hE8) return 2;
        if (i <= 'hDF || i == 'hF7 || (i >= 'hF9 && i <= 'hFB) || i >= 'hFD) return 1;
        return 0;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(8, rd_data, 8'h00, "idle rd_data"); // R8
        check(10, {7'd0, wr_reject}, 8'h00, "reject after reset"); // R10

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][43:40] == 4'h1)
                do_read(VEC[v][39:24], int'(VEC[v][7:0]), VEC[v][15:8]);
            else
                do_write(VEC[v][39:24], VEC[v][23:16], int'(VEC[v][7:0]), VEC[v][8], 1'b1);
        end

        // R10: pulse lasts exactly one cycle
        do_write(16'h03F0, 8'h10, 10, 1'b0, 1'b1);
        do_write(16'h03F1, 8'h01, 10, 1'b1, 1'b1);
        @(negedge clk);
        check(10, {7'd0, wr_reject}, 8'h00, "pulse width");

        // R9: reset with dirty state
        do_write(16'h03F0, 8'hE7, 9, 1'b0, 1'b0);
        do_write(16'h03F1, 8'hFE, 9, 1'b0, 1'b0);
        do_write(16'h03F0, 8'hF8, 9, 1'b0, 1'b0);
        do_write(16'h03F1, 8'hAA, 9, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(16'h03F0, 9, 8'h00);
        do_write(16'h03F0, 8'hF8, 9, 1'b0, 1'b0);
        do_read(16'h03F1, 9, 8'h00);

        // Sweep every index: R3 R4 R5 R6 R9
        for (int i = 0; i < 256; i++) begin
            automatic logic [7:0] d = 8'h5A ^ 8'(i);
            automatic int k = tb_kind(i);
            automatic logic [7:0] exp;
            if (k == 0) exp = d;
            else if (k == 1) exp = 8'h00;
            else exp = (i == 'hE7) ? 8'hFE : 8'hBE;
            do_write(16'h03F0, 8'(i), 1, 1'b0, 1'b1);
            do_write(16'h03F1, d, (k == 0) ? 3 : (k == 1) ? 4 : 5, (k != 0), 1'b1);
            do_read(16'h03F1, (k == 0) ? 3 : (k == 1) ? 4 : 6, exp);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule